// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the complete scan timing for a 50 Hz interlaced character display. On every character-time enable it moves a beam position through one scan line: active characters, then front porch, then horizontal sync, then back porch. It also moves the line position through one field. Fields alternate between a long field of 313 lines and a short field of 312 lines, so the frame averages 312.5 lines per field. On the short field the vertical sync pulse starts and ends at the middle of a line, which gives the half-line offset of interlace. Vertical sync is always three lines wide.

During active video the block gives the character column and the character row that a frame-buffer fetch needs. The row follows from a parameterised number of scan lines per character row. The vertical blanking interval is presented to the processor side as an access window. A single-cycle interrupt marks the first enable of the first blanked line. The format registers are sampled only at reset and at the start of each field, so a write in the middle of a field can never produce a malformed line.

Top module: `raster_timing_gen`

## Requirements
- R1: A scan line lasts exactly cfg_active_chars + cfg_front_porch + cfg_sync_width + cfg_back_porch character enables. The beam position moves only on cycles where char_en is 1.
- R2: hblank is high from character position cfg_active_chars to the end of the line. hsync is high for cfg_sync_width enables, starting cfg_front_porch enables after active video ends.
- R3: field is 0 after reset. It toggles as line 0 of a new field begins. A field with field=0 has LONG_FIELD_LINES (default 313) lines, and a field with field=1 has one line fewer.
- R4: vblank is high on every line whose index is at least cfg_active_rows × SCANS_PER_ROW, up to the end of the field, and low on all earlier lines. cpu_window is high exactly when vblank is high.
- R5: vsync is high for exactly three lines, beginning VFP_LINES lines after the first blanked line. With field=0 both of its edges fall at character position 0. With field=1 both edges fall at position floor(line length / 2).
- R6: vblank_irq is high for one clock, in the cycle where char_en is 1, the line is the first blanked line and the character position is 0. It occurs exactly once per field.
- R7: col equals the character position during active video and is 0 whenever hblank or vblank is high.
- R8: row equals the line index divided by SCANS_PER_ROW (integer division) on active lines and is 0 during vertical blanking.
- R9: The five format inputs are captured at reset and at the start of each field only. A change at any other time has no effect until the next field begins.
- R10: After reset, the beam is at line 0, character 0 of a field with field=0. hsync, hblank, vsync, vblank, cpu_window and vblank_irq are all 0, and col and row are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_en | input | 1 | Character-time enable; one beam step per high cycle |
| cfg_active_chars | input | 8 | Visible characters per line |
| cfg_front_porch | input | 8 | Front porch length in character times |
| cfg_sync_width | input | 8 | Horizontal sync length in character times |
| cfg_back_porch | input | 8 | Back porch length in character times |
| cfg_active_rows | input | 6 | Visible character rows per field |
| hsync | output | 1 | Horizontal sync, active high |
| hblank | output | 1 | Horizontal blanking |
| vsync | output | 1 | Vertical sync, active high |
| vblank | output | 1 | Vertical blanking |
| field | output | 1 | Field flag: 0 long field, 1 short half-line field |
| col | output | 8 | Character column for frame-buffer fetch |
| row | output | 6 | Character row for frame-buffer fetch |
| cpu_window | output | 1 | Processor access to display memory permitted |
| vblank_irq | output | 1 | One-clock interrupt at the start of vertical blanking |

## Verification
A wrong character position shows up at the ports within a single line. The hsync and hblank edges and the col value shift on the very next enable. A wrong line index or a wrong field flag can stay hidden until the blanking boundary of that field. It then shows as a vblank, vsync or interrupt edge on the wrong line, or as a field length of the wrong parity. For this reason the bench compares every output on every clock against a behavioural model, and also measures whole line and field periods. A shadow register that is reloaded at the wrong time changes the line length or the blank boundary within one line of the bad load.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CHAR_W = 8;
    localparam int ROW_W  = 6;
    localparam int LINE_W = 10;
    localparam int HPOS_W = CHAR_W + 2;

    typedef logic [CHAR_W-1:0] chr_t;
    typedef logic [HPOS_W-1:0] hpos_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [ROW_W-1:0]  crow_t;

    typedef struct packed {
        chr_t  active;
        chr_t  front;
        chr_t  sync;
        chr_t  back;
        crow_t rows;
    } raster_cfg_t;

    typedef struct packed {
        logic at_line_end;
        logic at_line_start;
        logic past_mid;
        logic hblank;
        logic hsync;
    } hstate_t;

    function automatic hpos_t line_total(input raster_cfg_t c);
        return hpos_t'(c.active) + hpos_t'(c.front) + hpos_t'(c.sync) + hpos_t'(c.back);
    endfunction

    function automatic hpos_t line_mid(input raster_cfg_t c);
        return line_total(c) >> 1;
    endfunction

endpackage

// File: rtl/raster_htimer.sv
module raster_htimer
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ce,
    input  raster_cfg_t cfg,
    output hpos_t       hcnt,
    output hstate_t     hs
);

    hpos_t total;
    hpos_t act_end;
    hpos_t sync_start;
    hpos_t sync_end;

    always_comb begin
        total      = line_total(cfg);
        act_end    = hpos_t'(cfg.active);
        sync_start = act_end + hpos_t'(cfg.front);
        sync_end   = sync_start + hpos_t'(cfg.sync);
    end

    always_comb begin
        hs.at_line_end   = (hcnt >= total - hpos_t'(1));
        hs.at_line_start = (hcnt == '0);
        hs.past_mid      = (hcnt >= line_mid(cfg));
        hs.hblank        = (hcnt >= act_end);
        hs.hsync         = (hcnt >= sync_start) && (hcnt < sync_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
        end else if (ce) begin
            if (hs.at_line_end) hcnt <= '0;
            else                hcnt <= hcnt + hpos_t'(1);
        end
    end

    assert_hold_no_enable_R1: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(hcnt));

    assert_line_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (ce && hs.at_line_end) |=> (hcnt == '0));

    assert_sync_inside_blank_R2: assert property (@(posedge clk) disable iff (rst)
        hs.hsync |-> hs.hblank);

endmodule

// File: rtl/raster_vtimer.sv
module raster_vtimer
    import raster_pkg::*;
#(
    parameter int SCANS_PER_ROW    = 12,
    parameter int LONG_FIELD_LINES = 313,
    parameter int VFP_LINES        = 4
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce,
    input  hstate_t hs,
    input  crow_t   rows,
    output line_t   vline,
    output logic    field,
    output logic    vblank,
    output logic    vsync,
    output logic    field_step,
    output logic    irq
);

    localparam int    VSYNC_LINES = 3;
    localparam line_t SCANS_L     = line_t'(SCANS_PER_ROW);
    localparam line_t LAST_LONG   = line_t'(LONG_FIELD_LINES - 1);
    localparam line_t LAST_SHORT  = line_t'(LONG_FIELD_LINES - 2);

    line_t act_lines;
    line_t vs_first;
    line_t vs_last_edge;
    line_t last_line;
    logic  line_step;

    always_comb begin
        act_lines    = line_t'(rows) * SCANS_L;
        vs_first     = act_lines + line_t'(VFP_LINES);
        vs_last_edge = vs_first + line_t'(VSYNC_LINES);
        last_line    = field ? LAST_SHORT : LAST_LONG;
        line_step    = ce && hs.at_line_end;
        field_step   = line_step && (vline == last_line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vline <= '0;
            field <= 1'b0;
        end else if (line_step) begin
            if (vline == last_line) begin
                vline <= '0;
                field <= ~field;
            end else begin
                vline <= vline + line_t'(1);
            end
        end
    end

    always_comb begin
        vblank = (vline >= act_lines);
        if (!field) begin
            vsync = (vline >= vs_first) && (vline < vs_last_edge);
        end else begin
            vsync = ((vline == vs_first) && hs.past_mid)
                 || ((vline > vs_first) && (vline < vs_last_edge))
                 || ((vline == vs_last_edge) && !hs.past_mid);
        end
        irq = ce && hs.at_line_start && (vline == act_lines);
    end

    assert_vsync_inside_blank_R5: assert property (@(posedge clk) disable iff (rst)
        vsync |-> vblank);

    assert_field_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        field_step |=> (field != $past(field)));

    assert_line_bound_R3: assert property (@(posedge clk) disable iff (rst)
        vline <= LAST_LONG);

endmodule

// File: rtl/raster_addr.sv
module raster_addr
    import raster_pkg::*;
#(
    parameter int SCANS_PER_ROW = 12
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_step,
    input  logic  field_step,
    input  hpos_t hcnt,
    input  logic  hblank,
    input  logic  vblank,
    input  crow_t rows,
    output chr_t  col,
    output crow_t row
);

    localparam int SC_W = (SCANS_PER_ROW > 1) ? $clog2(SCANS_PER_ROW) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SCANS_PER_ROW - 1);

    logic [SC_W-1:0] scan;
    crow_t           row_cnt;

    always_ff @(posedge clk) begin
        if (rst || field_step) begin
            scan    <= '0;
            row_cnt <= '0;
        end else if (line_step) begin
            if (scan == SC_LAST) begin
                scan <= '0;
                if (row_cnt != '1) row_cnt <= row_cnt + crow_t'(1);
            end else begin
                scan <= scan + SC_W'(1);
            end
        end
    end

    always_comb begin
        col = (hblank || vblank) ? '0 : hcnt[CHAR_W-1:0];
        row = vblank ? '0 : row_cnt;
    end

    assert_row_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        !vblank |-> (row_cnt < rows));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int SCANS_PER_ROW    = 12,
    parameter int LONG_FIELD_LINES = 313,
    parameter int VFP_LINES        = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              char_en,
    input  logic [CHAR_W-1:0] cfg_active_chars,
    input  logic [CHAR_W-1:0] cfg_front_porch,
    input  logic [CHAR_W-1:0] cfg_sync_width,
    input  logic [CHAR_W-1:0] cfg_back_porch,
    input  logic [ROW_W-1:0]  cfg_active_rows,
    output logic              hsync,
    output logic              hblank,
    output logic              vsync,
    output logic              vblank,
    output logic              field,
    output logic [CHAR_W-1:0] col,
    output logic [ROW_W-1:0]  row,
    output logic              cpu_window,
    output logic              vblank_irq
);

    raster_cfg_t incoming;
    raster_cfg_t shadow;
    hpos_t       hcnt;
    hstate_t     hs;
    line_t       vline;
    logic        field_step;

    always_comb begin
        incoming.active = cfg_active_chars;
        incoming.front  = cfg_front_porch;
        incoming.sync   = cfg_sync_width;
        incoming.back   = cfg_back_porch;
        incoming.rows   = cfg_active_rows;
    end

    always_ff @(posedge clk) begin
        if (rst || field_step) shadow <= incoming;
    end

    raster_htimer u_htimer (
        .clk  (clk),
        .rst  (rst),
        .ce   (char_en),
        .cfg  (shadow),
        .hcnt (hcnt),
        .hs   (hs)
    );

    raster_vtimer #(
        .SCANS_PER_ROW    (SCANS_PER_ROW),
        .LONG_FIELD_LINES (LONG_FIELD_LINES),
        .VFP_LINES        (VFP_LINES)
    ) u_vtimer (
        .clk        (clk),
        .rst        (rst),
        .ce         (char_en),
        .hs         (hs),
        .rows       (shadow.rows),
        .vline      (vline),
        .field      (field),
        .vblank     (vblank),
        .vsync      (vsync),
        .field_step (field_step),
        .irq        (vblank_irq)
    );

    raster_addr #(
        .SCANS_PER_ROW (SCANS_PER_ROW)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .line_step  (char_en && hs.at_line_end),
        .field_step (field_step),
        .hcnt       (hcnt),
        .hblank     (hs.hblank),
        .vblank     (vblank),
        .rows       (shadow.rows),
        .col        (col),
        .row        (row)
    );

    always_comb begin
        hsync      = hs.hsync;
        hblank     = hs.hblank;
        cpu_window = vblank;
    end

    assert_irq_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |=> !vblank_irq);

    assert_cfg_held_mid_field_R9: assert property (@(posedge clk) disable iff (rst)
        !field_step |=> $stable(shadow));

    assert_window_only_blank_R4: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |-> cpu_window);

endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
    import raster_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SCANS      = 12;
    localparam int LONG       = 313;
    localparam int VFP        = 4;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic char_en = 1'b0;
    logic [CHAR_W-1:0] cfg_a = 8'd20, cfg_fp = 8'd3, cfg_sw = 8'd4, cfg_bp = 8'd5;
    logic [ROW_W-1:0]  cfg_rows = 6'd24;
    logic hsync, hblank, vsync, vblank, field, cpu_window, vblank_irq;
    logic [CHAR_W-1:0] col;
    logic [ROW_W-1:0]  row;

    raster_timing_gen dut (
        .clk(clk), .rst(rst), .char_en(char_en),
        .cfg_active_chars(cfg_a), .cfg_front_porch(cfg_fp),
        .cfg_sync_width(cfg_sw), .cfg_back_porch(cfg_bp),
        .cfg_active_rows(cfg_rows),
        .hsync(hsync), .hblank(hblank), .vsync(vsync), .vblank(vblank),
        .field(field), .col(col), .row(row),
        .cpu_window(cpu_window), .vblank_irq(vblank_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // enable pattern driver
    int ce_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        char_en = (ce_mode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
    end

    // behavioural reference
    int m_h = 0, m_v = 0, m_f = 0;
    int sa = 0, sfp = 0, ssw = 0, sbp = 0, srows = 0;
    int ce_count = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_h = 0; m_v = 0; m_f = 0;
            sa = cfg_a; sfp = cfg_fp; ssw = cfg_sw; sbp = cfg_bp; srows = cfg_rows;
        end else if (char_en) begin
            ce_count++;
            if (m_h == sa + sfp + ssw + sbp - 1) begin
                m_h = 0;
                if (m_v == ((m_f != 0) ? LONG - 2 : LONG - 1)) begin
                    m_v = 0;
                    m_f = 1 - m_f;
                    sa = cfg_a; sfp = cfg_fp; ssw = cfg_sw; sbp = cfg_bp; srows = cfg_rows;
                end else begin
                    m_v++;
                end
            end else begin
                m_h++;
            end
        end
    end

    // per-clock comparison and aggregate measurements
    int   cmp_en = 0;
    int   agg_en = 0;
    int   agg_tot = 32;
    logic hs_prev = 0, hb_prev = 0, vs_prev = 0, fld_prev = 0;
    int   hs_at = 0, hb_at = 0, vs_at = 0, have_rise = 0;
    int   lines_in_field = 0, irqs_in_field = 0;

    always @(negedge clk) begin
        if (!rst && cmp_en != 0) begin
            int tot, act, vs0, half, e_vs, active;
            tot  = sa + sfp + ssw + sbp;
            act  = srows * SCANS;
            vs0  = act + VFP;
            half = tot / 2;
            if (m_f == 0) e_vs = (m_v >= vs0 && m_v < vs0 + 3) ? 1 : 0;
            else e_vs = ((m_v == vs0 && m_h >= half) || (m_v > vs0 && m_v < vs0 + 3)
                         || (m_v == vs0 + 3 && m_h < half)) ? 1 : 0;
            active = (m_h < sa && m_v < act) ? 1 : 0;
            chk("R1/R2 hblank", int'(hblank), (m_h >= sa) ? 1 : 0);
            chk("R2 hsync", int'(hsync), (m_h >= sa + sfp && m_h < sa + sfp + ssw) ? 1 : 0);
            chk("R4 vblank", int'(vblank), (m_v >= act) ? 1 : 0);
            chk("R4 cpu_window", int'(cpu_window), (m_v >= act) ? 1 : 0);
            chk("R5 vsync", int'(vsync), e_vs);
            chk("R3 field", int'(field), m_f);
            chk("R6 irq", int'(vblank_irq), (char_en && m_v == act && m_h == 0) ? 1 : 0);
            chk("R7 col", int'(col), (active != 0) ? m_h : 0);
            chk("R8 row", int'(row), (m_v < act) ? m_v / SCANS : 0);

            if (agg_en != 0) begin
                if (hsync && !hs_prev) begin
                    if (have_rise != 0) chk("R1 line period", ce_count - hs_at, agg_tot);
                    have_rise = 1;
                    lines_in_field++;
                end
                if (!hsync && hs_prev) chk("R2 hsync width", ce_count - hs_at, ssw);
                if (!hblank && hb_prev) chk("R2 hblank width", ce_count - hb_at, sfp + ssw + sbp);
                if (!vsync && vs_prev) chk("R5 vsync width", ce_count - vs_at, 3 * agg_tot);
                if (vblank_irq) irqs_in_field++;
                if (field != fld_prev) begin
                    chk("R3 lines per field", lines_in_field, fld_prev ? LONG - 1 : LONG);
                    chk("R6 irq per field", irqs_in_field, 1);
                    lines_in_field = 0;
                    irqs_in_field = 0;
                end
            end
        end
        if (hsync && !hs_prev) hs_at = ce_count;
        if (hblank && !hb_prev) hb_at = ce_count;
        if (vsync && !vs_prev) vs_at = ce_count;
        hs_prev = hsync; hb_prev = hblank; vs_prev = vsync; fld_prev = field;
    end

    task automatic wait_field_toggle();
        logic f0;
        f0 = field;
        while (field == f0) @(negedge clk);
    endtask

    task automatic wait_hs_rise();
        logic p;
        do begin
            p = hsync;
            @(negedge clk);
        end while (!(hsync && !p));
    endtask

    task automatic check_reset_state();
        chk("R10 hsync", int'(hsync), 0);
        chk("R10 hblank", int'(hblank), 0);
        chk("R10 vsync", int'(vsync), 0);
        chk("R10 vblank", int'(vblank), 0);
        chk("R10 cpu_window", int'(cpu_window), 0);
        chk("R10 irq", int'(vblank_irq), 0);
        chk("R10 field", int'(field), 0);
        chk("R10 col", int'(col), 0);
        chk("R10 row", int'(row), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0 cycles left", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_reset_state();
        cmp_en = 1;
        agg_en = 1;
        ce_mode = 1;

        // two full fields with irregular enables, first format
        wait_field_toggle();
        wait_field_toggle();

        // R9: mid-field write must not change the running line length
        wait_hs_rise();
        wait_hs_rise();
        agg_en = 0;
        @(posedge clk);
        #1;
        cfg_a = 8'd10; cfg_fp = 8'd2; cfg_sw = 8'd3; cfg_bp = 8'd1; cfg_rows = 6'd20;
        wait_hs_rise();
        t0 = ce_count;
        wait_hs_rise();
        chk("R9 line length after mid-field write", ce_count - t0, 32);

        // second format takes effect at the next field, then steady enables
        wait_field_toggle();
        wait_field_toggle();
        ce_mode = 0;
        wait_field_toggle();
        wait_hs_rise();
        t0 = ce_count;
        wait_hs_rise();
        chk("R1 line length second format", ce_count - t0, 16);

        // reset in the middle of vertical blanking
        while (!vblank) @(negedge clk);
        @(posedge clk);
        #1 rst = 1'b1;
        cmp_en = 0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_reset_state();
        cmp_en = 1;
        repeat (200) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule